// File: doc/BRIEF.md
# I2C Sensor Register Interface

This block is a two-wire serial slave that lets a host reach a small register file behind a pointer. The slave runs entirely on the system clock. SCL and SDA are oversampled through synchronisers, and edge detectors turn them into single-cycle events. A transaction starts with an address byte. A write then sends a pointer byte, optionally followed by data for the selected register. A read returns the register the pointer currently selects. The pointer keeps its value between transactions, so a host can poll the same register again and again without rewriting it.

The register file has four slots. Slot 0 is a 16-bit temperature word supplied by the sensing logic, and it is read-only. Slot 1 is an 8-bit configuration byte. Slots 2 and 3 are 16-bit low and high setpoints. The configuration byte and both setpoints leave the block as plain outputs for the thermostat logic. Every read transaction raises a one-cycle strobe, which the alarm logic uses as its clear event.

The SDA output is an open-drain pull-down enable: 1 pulls the line low and 0 releases it. The system clock must run at least ten times faster than SCL.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The address byte is compared as bits [7:4] = 1001, bits [3:1] = dev_sel_i, and bit 0 = direction (1 = read). Only a full match is acknowledged. On a mismatch the slave never pulls SDA until the next START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START in the middle of a transaction begins a new address phase and drops any partly received register word.
- R3: The first data byte of a write is the pointer. Values 00h–03h are acknowledged and stored, where 00h = temperature, 01h = configuration, 02h = low setpoint and 03h = high setpoint. Larger values are not acknowledged and leave the pointer unchanged. The pointer is 00h after reset and keeps its value across transactions.
- R4: Read data goes out MSb first. For a 16-bit slot the high byte comes first, then the low byte, and further bytes alternate high and low. After the master answers a byte with a not-acknowledge, the slave releases SDA.
- R5: Reading the configuration slot returns the same single byte for every byte the master clocks.
- R6: A 16-bit setpoint changes only once both its high byte and its low byte have been received. A transaction that ends after the high byte leaves the setpoint unchanged.
- R7: The configuration byte resets to 00h. Bit 7 is always stored as 0, whatever the host writes.
- R8: Data bytes written while the pointer is 00h are acknowledged but have no effect on any register.
- R9: rd_strobe_o is high for exactly one clock for each read address byte that is acknowledged, and at no other time.
- R10: The setpoints reset to 4B00h (low) and 5000h (high) and hold any value the host writes.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| dev_sel_i | input | 3 | Device select bits of the slave address |
| temp_i | input | 16 | Temperature word from the sensing logic |
| cfg_o | output | 8 | Configuration byte |
| set_lo_o | output | 16 | Low setpoint |
| set_hi_o | output | 16 | High setpoint |
| rd_strobe_o | output | 1 | One-cycle pulse per acknowledged read address |

## Verification
The bench hunts for a setpoint that commits on its high byte alone. It does so by ending a write after the high byte and by breaking one off with a repeated START; a slave that commits early would show the half-written value at once in the per-clock register comparison. A pointer byte above 03h is sent right after a valid pointer, and the following pointer-less read shows whether a design wrongly accepted the bad value. Bytes written to the temperature slot, an all-ones configuration write, and multi-byte reads of both the configuration slot and the 16-bit slots expose a missing bit-7 mask, a missing write block, or a wrong byte order.

// File: rtl/i2c_rf_pkg.sv
// Shared types for the I2C register-file slave.
// Assumes: four register slots selected by a two-bit pointer.
package i2c_rf_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_SACK, ST_TX, ST_MACK} bus_st_t;
    typedef enum logic [1:0] {RX_ADDR, RX_PTR, RX_DATA} rx_kind_t;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [1:0] PTR_TEMP = 2'd0;
    localparam logic [1:0] PTR_CFG  = 2'd1;
    localparam logic [1:0] PTR_LO   = 2'd2;
    localparam logic [1:0] PTR_HI   = 2'd3;
endpackage

// File: rtl/i2c_rf_sync.sv
// Line synchroniser with edge detection for one bus wire.
// Assumes: STAGES >= 2 and an idle-high line, so reset loads ones.
module i2c_rf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the flop chain and keep the last settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;
    assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_rf_regs.sv
// Register file behind the pointer: a read-only temperature word, a
// configuration byte and two setpoint words.
// Assumes: a write is a single-cycle strobe carrying the whole word.
module i2c_rf_regs
    import i2c_rf_pkg::*;
#(
    parameter logic [WORD_W-1:0] LO_RST = 16'h4B00,
    parameter logic [WORD_W-1:0] HI_RST = 16'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        wptr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] temp_i,
    input  logic [1:0]        rptr_i,
    input  logic              rlow_i,
    output logic [BYTE_W-1:0] rbyte_o,
    output logic [BYTE_W-1:0] cfg_o,
    output logic [WORD_W-1:0] lo_o,
    output logic [WORD_W-1:0] hi_o
);
    // Store writes; the temperature slot takes none, and cfg bit 7 stays 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
            lo_o  <= LO_RST;
            hi_o  <= HI_RST;
        end else if (we_i) begin
            case (wptr_i)
                PTR_CFG: cfg_o <= {1'b0, wdata_i[BYTE_W-2:0]};
                PTR_LO:  lo_o  <= wdata_i;
                PTR_HI:  hi_o  <= wdata_i;
                default: ;
            endcase
        end
    end

    // Select the outgoing byte: high half first unless the low half is asked.
    always_comb begin
        case (rptr_i)
            PTR_CFG: rbyte_o = cfg_o;
            PTR_LO:  rbyte_o = rlow_i ? lo_o[BYTE_W-1:0]   : lo_o[WORD_W-1:BYTE_W];
            PTR_HI:  rbyte_o = rlow_i ? hi_o[BYTE_W-1:0]   : hi_o[WORD_W-1:BYTE_W];
            default: rbyte_o = rlow_i ? temp_i[BYTE_W-1:0] : temp_i[WORD_W-1:BYTE_W];
        endcase
    end

    AST_TEMP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wptr_i == PTR_TEMP) |=> ($stable(cfg_o) && $stable(lo_o) && $stable(hi_o))); // R8
endmodule

// File: rtl/i2c_regfile_slave.sv
// Two-wire serial slave giving pointer-based access to the register file.
// Assumes: clk at least 10x SCL; no clock stretching; 7-bit addressing only.
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter int                PFX_W       = 4,
    parameter int                SEL_W       = 3,
    parameter logic [PFX_W-1:0]  ADDR_PREFIX = 4'b1001,
    parameter int                SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] LO_RST      = 16'h4B00,
    parameter logic [WORD_W-1:0] HI_RST      = 16'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [SEL_W-1:0]  dev_sel_i,
    input  logic [WORD_W-1:0] temp_i,
    output logic [BYTE_W-1:0] cfg_o,
    output logic [WORD_W-1:0] set_lo_o,
    output logic [WORD_W-1:0] set_hi_o,
    output logic              rd_strobe_o
);
    localparam int          ADDR_W   = PFX_W + SEL_W;
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start, stop;

    bus_st_t           state;
    rx_kind_t          kind;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, hi_byte, rbyte;
    logic [1:0]        ptr;
    logic              is_read, mack, byte_idx, rsel;
    logic              wr_stb;
    logic [WORD_W-1:0] wr_data;

    i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));
    i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    assign start = scl_lvl & sda_fall;
    assign stop  = scl_lvl & sda_rise;
    assign rsel  = (state == ST_MACK && ptr != PTR_CFG) ? ~byte_idx : byte_idx;

    i2c_rf_regs #(.LO_RST(LO_RST), .HI_RST(HI_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(wr_stb), .wptr_i(ptr), .wdata_i(wr_data),
        .temp_i(temp_i), .rptr_i(ptr), .rlow_i(rsel), .rbyte_o(rbyte),
        .cfg_o(cfg_o), .lo_o(set_lo_o), .hi_o(set_hi_o));

    // Bus protocol engine: framing, address match, acknowledge, shift in and out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            kind        <= RX_ADDR;
            cnt         <= '0;
            shreg       <= '0;
            hi_byte     <= '0;
            ptr         <= PTR_TEMP;
            is_read     <= 1'b0;
            mack        <= 1'b0;
            byte_idx    <= 1'b0;
            sda_pull_o  <= 1'b0;
            rd_strobe_o <= 1'b0;
            wr_stb      <= 1'b0;
            wr_data     <= '0;
        end else begin
            rd_strobe_o <= 1'b0;
            wr_stb      <= 1'b0;
            if (start) begin
                state      <= ST_RX;
                kind       <= RX_ADDR;
                cnt        <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop) begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && cnt != FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            state    <= ST_IDLE;
                            byte_idx <= 1'b0;
                            case (kind)
                                RX_ADDR: if (shreg[BYTE_W-1:1] == ADDR_W'({ADDR_PREFIX, dev_sel_i})) begin
                                    state       <= ST_SACK;
                                    sda_pull_o  <= 1'b1;
                                    is_read     <= shreg[0];
                                    rd_strobe_o <= shreg[0];
                                end
                                RX_PTR: if (shreg[BYTE_W-1:2] == '0) begin
                                    ptr        <= shreg[1:0];
                                    state      <= ST_SACK;
                                    sda_pull_o <= 1'b1;
                                end
                                default: begin
                                    state      <= ST_SACK;
                                    sda_pull_o <= 1'b1;
                                    if (ptr == PTR_CFG || byte_idx) begin
                                        wr_stb  <= 1'b1;
                                        wr_data <= (ptr == PTR_CFG) ? {{BYTE_W{1'b0}}, shreg}
                                                                    : {hi_byte, shreg};
                                    end else begin
                                        hi_byte  <= shreg;
                                        byte_idx <= 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_SACK: if (scl_fall) begin
                        cnt <= '0;
                        if (is_read) begin
                            state      <= ST_TX;
                            shreg      <= rbyte;
                            sda_pull_o <= ~rbyte[BYTE_W-1];
                            byte_idx   <= rsel;
                        end else begin
                            state      <= ST_RX;
                            kind       <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
                            sda_pull_o <= 1'b0;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (cnt == LAST) begin
                            sda_pull_o <= 1'b0;
                            state      <= ST_MACK;
                        end else begin
                            cnt        <= cnt + 1'b1;
                            shreg      <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_pull_o <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) mack <= ~sda_lvl;
                        if (scl_fall) begin
                            if (mack) begin
                                state      <= ST_TX;
                                cnt        <= '0;
                                shreg      <= rbyte;
                                sda_pull_o <= ~rbyte[BYTE_W-1];
                                byte_idx   <= rsel;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o); // R1
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull_o) && !$past(start) && !$past(stop)) |-> !$past(scl_lvl)); // R11
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_o |=> !rd_strobe_o); // R9
    AST_STROBE_ON_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_o |-> (state == ST_SACK && is_read && sda_pull_o)); // R9
    AST_BAD_PTR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX && kind == RX_PTR && scl_fall && cnt == FULL
         && shreg[BYTE_W-1:2] != '0 && !start && !stop) |=> (state == ST_IDLE && $stable(ptr))); // R3
endmodule

// File: tb/tb_i2c_regfile_slave.sv
module tb_i2c_regfile_slave;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [2:0]  dev_sel = 3'b101;
    logic [15:0] temp = 16'h1910;
    wire  sda_pull, rd_strobe;
    wire  [7:0]  cfg;
    wire  [15:0] set_lo, set_hi;
    wire  sda_line = m_sda & ~sda_pull;

    int n_chk = 0, n_fail = 0, strobes = 0;
    logic [7:0]  m_cfg = 8'h00;
    logic [15:0] m_lo = 16'h4B00, m_hi = 16'h5000;
    bit cmp_on = 1'b0, done = 1'b0;
    logic p_oe = 1'b0, p_scl = 1'b1;

    always #2 clk = ~clk;

    i2c_regfile_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .dev_sel_i(dev_sel), .temp_i(temp),
        .cfg_o(cfg), .set_lo_o(set_lo), .set_hi_o(set_hi), .rd_strobe_o(rd_strobe));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the behavioural register model.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R6/R7/R10 regs", {cfg, set_lo, set_hi[7:0]}, {m_cfg, m_lo, m_hi[7:0]});
            chk("R6/R10 hi", {16'h0, set_hi}, {16'h0, m_hi});
        end
        if (rst_n && sda_pull !== p_oe && m_scl && p_scl)
            chk("R11 drive changed with SCL high", 1, 0);
        p_oe  <= sda_pull;
        p_scl <= m_scl;
    end
    always @(posedge clk) if (rst_n && rd_strobe) strobes++;

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask
    task automatic wbit(logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    endtask
    task automatic rbit(output logic b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); b = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
    endtask
    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask
    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
    endtask
    task automatic send(logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(x);
        ack = ~x;
    endtask
    task automatic recv(output logic [7:0] b, input logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin rbit(x); b[i] = x; end
        wbit(~ack);
    endtask
    // Data byte that may commit a register: compare is paused around it.
    task automatic send_commit(logic [7:0] b, string tag);
        logic a;
        cmp_on = 1'b0; send(b, a); chk(tag, a, 1);
    endtask

    localparam logic [7:0] AW = {4'b1001, 3'b101, 1'b0};
    localparam logic [7:0] AR = {4'b1001, 3'b101, 1'b1};

    task automatic read2(string tag, logic [15:0] exp);
        logic a; logic [7:0] b0, b1;
        bus_start(); send(AR, a); chk({tag, " ack"}, a, 1);
        recv(b0, 1'b1); recv(b1, 1'b0); bus_stop();
        chk(tag, {b0, b1}, exp);
    endtask

    initial begin
        logic a; logic [7:0] b0, b1, b2;
        tick(5); rst_n = 1'b1; tick(1);
        chk("R7 cfg reset", cfg, 8'h00);
        chk("R10 low setpoint reset", set_lo, 16'h4B00);
        chk("R10 high setpoint reset", set_hi, 16'h5000);
        chk("R1 no drive at reset", sda_pull, 0);
        chk("R9 strobe low at reset", rd_strobe, 0);
        cmp_on = 1'b1;

        // R3 pointer defaults to temperature; R4 high byte first
        read2("R3/R4 temperature read", 16'h1910);
        chk("R9 one strobe per read", strobes, 1);

        // R1 wrong select bits and wrong prefix are not acknowledged
        bus_start(); send({4'b1001, 3'b100, 1'b1}, a); bus_stop();
        chk("R1 select mismatch nack", a, 0);
        bus_start(); send({4'b1011, 3'b101, 1'b0}, a); bus_stop();
        chk("R1 prefix mismatch nack", a, 0);
        chk("R9 no strobe on mismatch", strobes, 1);

        // R6 high setpoint write; first byte alone must not commit
        bus_start(); send(AW, a); chk("R1 write ack", a, 1);
        send(8'h03, a); chk("R3 pointer 03 ack", a, 1);
        send(8'h12, a); chk("R6 high byte ack", a, 1);
        send_commit(8'h34, "R6 low byte ack");
        m_hi = 16'h1234; cmp_on = 1'b1; bus_stop();

        // R3 pointer persists; R4 bytes alternate
        bus_start(); send(AR, a);
        recv(b0, 1'b1); recv(b1, 1'b1); recv(b2, 1'b0); bus_stop();
        chk("R4 alternating read", {8'h0, b0, b1, b2}, 32'h00123412);

        // R7 config write masks bit 7; R5 single byte repeats; R2 repeated start
        bus_start(); send(AW, a); send(8'h01, a);
        send_commit(8'hFF, "R7 cfg data ack");
        m_cfg = 8'h7F; cmp_on = 1'b1;
        bus_start(); send(AR, a); chk("R2 repeated start address ack", a, 1);
        recv(b0, 1'b1); recv(b1, 1'b0); bus_stop();
        chk("R5 config repeats", {b0, b1}, 16'h7F7F);

        // R8 writes to the temperature slot acked, no effect
        bus_start(); send(AW, a); send(8'h00, a);
        send(8'hAA, a); chk("R8 temp write ack", a, 1);
        send(8'hBB, a); chk("R8 temp write ack 2", a, 1);
        bus_stop();
        read2("R8 temperature unchanged", 16'h1910);

        // R3 out-of-range pointer is refused and leaves the pointer
        bus_start(); send(AW, a); send(8'h02, a); bus_stop();
        bus_start(); send(AW, a); send(8'h07, a); bus_stop();
        chk("R3 pointer 07 nack", a, 0);
        read2("R3 pointer kept after refusal", 16'h4B00);

        // R6 incomplete write leaves register
        bus_start(); send(AW, a); send(8'h02, a); send(8'h99, a); bus_stop();
        read2("R6 incomplete write ignored", 16'h4B00);
        bus_start(); send(AW, a); send(8'h02, a); send(8'h87, a);
        send_commit(8'h65, "R6 low setpoint commit ack");
        m_lo = 16'h8765; cmp_on = 1'b1; bus_stop();
        read2("R10 low setpoint storage", 16'h8765);

        // R2 repeated start after a lone high byte drops it
        bus_start(); send(AW, a); send(8'h03, a); send(8'h55, a);
        bus_start(); send(AR, a); recv(b0, 1'b1); recv(b1, 1'b0); bus_stop();
        chk("R2 repeated start drops half word", {b0, b1}, 16'h1234);

        // R4 release after master not-acknowledge
        tick(4);
        chk("R4 released after nack", sda_pull, 0);
        chk("R9 strobe count", strobes, 8);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule